// File: doc/BRIEF.md
# Data Cache Access Policy Controller

This block takes load and store requests from a single requester and decides, per access, whether the data goes through a small direct-mapped data cache, through a four-entry write buffer, or straight to external memory. The decision combines two global control bits with two per-page attribute bits. The global bits are cache enable and translation enable. The page bits are cacheable and bufferable, and they arrive already resolved with each request. The block then carries out the access on a single external memory port: a cache lookup, an eight-word linefill, a cache update together with a buffered store, a buffered store alone, or an unbuffered store that completes only when memory acknowledges it.

Only one request is in flight at a time. The requester offers a request with `req_valid` while `req_ready` is high. Completion comes back as a one-cycle `done` pulse, with read data in `rdata` during that cycle. The write buffer drains in the background whenever the controller itself is not using the memory port. Before any external read or unbuffered store is issued, the buffer is emptied, so memory sees all traffic in program order.

Top module: `dcache_policy_ctrl`

## Requirements
- R1: Once reset is released, `req_ready` is 1 while `done` and `mem_req` are both 0.
- R2: While either global bit (`cache_en`, `xlat_en`) is 0, the page bits have no effect. A read makes exactly one external read and returns memory data, with no cache lookup and no cache fill. A write is an unbuffered store.
- R3: With both global bits at 1 and page bits cacheable=0 and bufferable=0, a read makes one external read. A write is an unbuffered store, so `done` comes only after memory has acknowledged that store.
- R4: With both global bits at 1, cacheable=0 and bufferable=1, a write goes into the write buffer and `done` is given without waiting for memory. The store reaches memory later. A read makes one external read.
- R5: With both global bits at 1 and cacheable=1, a read miss fetches the whole line as 8 word reads. The reads start at the line base (address bits [4:0] cleared) and go up by 4. The block then returns the requested word. A later read anywhere in that line hits and makes no external read. The cache has 16 lines, indexed by address bits [8:5], and the tag is bits [31:9].
- R6: A write-through write hit (cacheable=1, bufferable=0) updates the cached word and also queues a buffered store. A later read hit returns the new value with no external read.
- R7: A write-through write miss only queues a buffered store and does not allocate a line. A later read of that address is still a miss and causes a full linefill.
- R8: Page bits cacheable=1 and bufferable=1 behave exactly like write-through, for hits, misses and non-allocation.
- R9: The write buffer holds 4 stores. A buffered store holds the requester back only while all 4 entries are occupied. It completes once memory frees an entry.
- R10: An external read or unbuffered store is issued only after every earlier store has reached memory. The final memory contents equal the last value written to each address.
- R11: `done` lasts exactly one cycle. It is high only while `req_ready` is high, and `rdata` is valid in that cycle for reads.
- R12: Once `mem_req` is raised, it stays high with `mem_addr`, `mem_write` and `mem_wdata` unchanged until a cycle with `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and accepting a request |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_addr | input | 32 | Byte address, word aligned |
| req_wdata | input | 32 | Store data |
| cache_en | input | 1 | Global cache enable |
| xlat_en | input | 1 | Global translation enable |
| pg_cache | input | 1 | Page attribute: cacheable |
| pg_buf | input | 1 | Page attribute: bufferable |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Load data, valid with `done` |
| mem_req | output | 1 | External access requested |
| mem_write | output | 1 | External access is a store |
| mem_addr | output | 32 | External word address (byte form) |
| mem_wdata | output | 32 | External store data |
| mem_ack | input | 1 | External access completes in this cycle |
| mem_rdata | input | 32 | External read data, valid with `mem_ack` |

## Verification
The hardest situation to reach is a full write buffer. At that point the fifth buffered store has to be held back, while an external read waiting behind queued stores must not overtake them. Random memory latency alone seldom fills all four entries. The stimulus therefore freezes memory acknowledges, issues four buffered stores that must each complete, then shows that a fifth one stalls until memory is released. The random phase sends reads and stores of every attribute mix to a small set of conflicting lines. On every external read, a count of completed memory stores is compared with the number of stores accepted so far.

// File: rtl/dcp_pkg.sv
// Shared types for the data cache access policy controller.
// Assumes nothing beyond IEEE 1800-2017 synthesizable constructs.
package dcp_pkg;

    // Sequencer states of the controller
    typedef enum logic [2:0] {
        ST_IDLE,    // waiting for a request
        ST_ACT,     // request latched, path decided
        ST_FILL,    // fetching a line word by word
        ST_EXT_RD,  // single uncached read
        ST_EXT_WR   // single unbuffered store
    } dcp_state_e;

endpackage

// File: rtl/dcp_policy.sv
// Access policy decoder.
// Turns the global enable pair and per-page attributes into two path
// choices: use the cache, and send stores through the write buffer.
// Assumes the write-back attribute pair is served as write-through.
module dcp_policy (
    input  logic cache_en,
    input  logic xlat_en,
    input  logic pg_cache,
    input  logic pg_buf,
    output logic use_cache,
    output logic use_buf
);

    logic paging_on;

    // Page bits matter only when both global bits are set
    always_comb begin
        paging_on = cache_en & xlat_en;
        use_cache = paging_on & pg_cache;
        use_buf   = paging_on & (pg_buf | pg_cache);
    end

endmodule

// File: rtl/dcp_wbuf.sv
// Write buffer: a small address/data FIFO that drains to external memory.
// Holds its head entry on the output until acknowledged.
// Assumes DEPTH is a power of two; push is never issued while full.
module dcp_wbuf #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    output logic          full,
    output logic          empty,
    output logic          out_req,
    output logic [AW-1:0] out_addr,
    output logic [DW-1:0] out_data,
    input  logic          out_ack
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = PTR_W + 1;

    logic [AW-1:0]    addr_mem [DEPTH];
    logic [DW-1:0]    data_mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q;
    logic [PTR_W-1:0] rd_ptr_q;
    logic [CNT_W-1:0] count_q;
    logic             pop;

    // Status and head-of-queue outputs
    always_comb begin
        empty    = (count_q == '0);
        full     = (count_q == CNT_W'(DEPTH));
        pop      = out_ack & ~empty;
        out_req  = ~empty;
        out_addr = addr_mem[rd_ptr_q];
        out_data = data_mem[rd_ptr_q];
    end

    // Entry storage, written on push
    always_ff @(posedge clk) begin
        if (push) begin
            addr_mem[wr_ptr_q] <= push_addr;
            data_mem[wr_ptr_q] <= push_data;
        end
    end

    // Pointer and occupancy tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push) wr_ptr_q <= wr_ptr_q + 1'b1;
            if (pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
            case ({push, pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

endmodule

// File: rtl/dcp_cache.sv
// Direct-mapped data store with tags and valid bits.
// One combinational lookup port, one word write port and a line
// validate port. Data words are not reset; valid bits are.
module dcp_cache #(
    parameter int DW         = 32,
    parameter int LINE_WORDS = 8,
    parameter int NUM_LINES  = 16,
    parameter int TAG_W      = 23
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [$clog2(NUM_LINES)-1:0]  idx,
    input  logic [$clog2(LINE_WORDS)-1:0] off,
    input  logic [TAG_W-1:0]              tag,
    output logic                          hit,
    output logic [DW-1:0]                 rd_word,
    input  logic                          wr_en,
    input  logic [$clog2(LINE_WORDS)-1:0] wr_off,
    input  logic [DW-1:0]                 wr_word,
    input  logic                          set_valid
);

    localparam int IDX_W = $clog2(NUM_LINES);
    localparam int OFF_W = $clog2(LINE_WORDS);
    localparam int WORDS = NUM_LINES * LINE_WORDS;

    logic [DW-1:0]    data_q  [WORDS];
    logic [TAG_W-1:0] tag_q   [NUM_LINES];
    logic [NUM_LINES-1:0] valid_q;

    // Tag compare and word select for the current request
    always_comb begin
        hit     = valid_q[idx] && (tag_q[idx] == tag);
        rd_word = data_q[{idx, off}];
    end

    // Word writes from linefill or write-through hit
    always_ff @(posedge clk) begin
        if (wr_en) data_q[{idx, wr_off}] <= wr_word;
    end

    // Tag capture and valid bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (set_valid) begin
            valid_q[idx] <= 1'b1;
            tag_q[idx]   <= tag;
        end
    end

    logic unused_w;
    assign unused_w = ^{IDX_W[0], OFF_W[0]};

endmodule

// File: rtl/dcache_policy_ctrl.sv
// Data cache access policy controller (top).
// Latches one request, picks its path from global and page bits, and
// sequences cache lookup, linefill, buffered or unbuffered stores on a
// single external port. External reads and unbuffered stores wait for
// the write buffer to drain. Assumes word-aligned 32-bit accesses.
module dcache_policy_ctrl
    import dcp_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 8,
    parameter int NUM_LINES  = 16,
    parameter int WB_DEPTH   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              cache_en,
    input  logic              xlat_en,
    input  logic              pg_cache,
    input  logic              pg_buf,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              mem_req,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int BYTE_W = $clog2(DATA_W / 8);
    localparam int OFF_W  = $clog2(LINE_WORDS);
    localparam int IDX_W  = $clog2(NUM_LINES);
    localparam int WA_W   = ADDR_W - BYTE_W;
    localparam int TAG_W  = WA_W - OFF_W - IDX_W;
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(LINE_WORDS - 1);

    dcp_state_e        state_q;
    logic [WA_W-1:0]   wa_q;
    logic [DATA_W-1:0] wdata_q;
    logic              wr_q, cach_q, buf_q;
    logic [OFF_W-1:0]  fill_cnt_q;
    logic              done_q;
    logic [DATA_W-1:0] rdata_q;

    logic              pol_cache, pol_buf;
    logic              hit;
    logic [DATA_W-1:0] line_word;
    logic              c_wr_en, c_set;
    logic [OFF_W-1:0]  c_wr_off;
    logic [DATA_W-1:0] c_wr_word;
    logic              wb_push, wb_full, wb_empty, wb_req, wb_ack;
    logic [ADDR_W-1:0] wb_addr, ext_addr;
    logic [DATA_W-1:0] wb_data;
    logic              fsm_mem;
    logic [OFF_W-1:0]  req_off;
    logic [IDX_W-1:0]  req_idx;
    logic [TAG_W-1:0]  req_tag;

    dcp_policy u_policy (
        .cache_en  (cache_en),
        .xlat_en   (xlat_en),
        .pg_cache  (pg_cache),
        .pg_buf    (pg_buf),
        .use_cache (pol_cache),
        .use_buf   (pol_buf)
    );

    // Field split of the latched word address
    always_comb begin
        req_off = wa_q[OFF_W-1:0];
        req_idx = wa_q[OFF_W +: IDX_W];
        req_tag = wa_q[WA_W-1 -: TAG_W];
    end

    dcp_cache #(
        .DW         (DATA_W),
        .LINE_WORDS (LINE_WORDS),
        .NUM_LINES  (NUM_LINES),
        .TAG_W      (TAG_W)
    ) u_cache (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (req_idx),
        .off       (req_off),
        .tag       (req_tag),
        .hit       (hit),
        .rd_word   (line_word),
        .wr_en     (c_wr_en),
        .wr_off    (c_wr_off),
        .wr_word   (c_wr_word),
        .set_valid (c_set)
    );

    dcp_wbuf #(
        .AW    (ADDR_W),
        .DW    (DATA_W),
        .DEPTH (WB_DEPTH)
    ) u_wbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wb_push),
        .push_addr (ext_addr),
        .push_data (wdata_q),
        .full      (wb_full),
        .empty     (wb_empty),
        .out_req   (wb_req),
        .out_addr  (wb_addr),
        .out_data  (wb_data),
        .out_ack   (wb_ack)
    );

    // Cache write and store-queue control derived from the state
    always_comb begin
        ext_addr  = {wa_q, {BYTE_W{1'b0}}};
        wb_push   = (state_q == ST_ACT) && wr_q && buf_q && !wb_full;
        c_wr_en   = (wb_push && cach_q && hit) || ((state_q == ST_FILL) && mem_ack);
        c_wr_off  = (state_q == ST_FILL) ? fill_cnt_q : req_off;
        c_wr_word = (state_q == ST_FILL) ? mem_rdata : wdata_q;
        c_set     = (state_q == ST_FILL) && mem_ack && (fill_cnt_q == LAST_OFF);
    end

    // External port ownership: sequencer first, otherwise buffer drain
    always_comb begin
        fsm_mem = (state_q == ST_FILL) || (state_q == ST_EXT_RD) || (state_q == ST_EXT_WR);
        wb_ack  = mem_ack && !fsm_mem;
        mem_req = fsm_mem || wb_req;
        if (state_q == ST_FILL) begin
            mem_write = 1'b0;
            mem_addr  = {wa_q[WA_W-1:OFF_W], fill_cnt_q, {BYTE_W{1'b0}}};
            mem_wdata = wdata_q;
        end else if (fsm_mem) begin
            mem_write = (state_q == ST_EXT_WR);
            mem_addr  = ext_addr;
            mem_wdata = wdata_q;
        end else begin
            mem_write = 1'b1;
            mem_addr  = wb_addr;
            mem_wdata = wb_data;
        end
    end

    // Request sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            wa_q       <= '0;
            wdata_q    <= '0;
            wr_q       <= 1'b0;
            cach_q     <= 1'b0;
            buf_q      <= 1'b0;
            fill_cnt_q <= '0;
            done_q     <= 1'b0;
            rdata_q    <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        wa_q    <= req_addr[ADDR_W-1:BYTE_W];
                        wdata_q <= req_wdata;
                        wr_q    <= req_write;
                        cach_q  <= pol_cache;
                        buf_q   <= pol_buf;
                        state_q <= ST_ACT;
                    end
                end
                ST_ACT: begin
                    if (!wr_q) begin
                        if (cach_q && hit) begin
                            rdata_q <= line_word;
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else if (wb_empty) begin
                            fill_cnt_q <= '0;
                            state_q    <= cach_q ? ST_FILL : ST_EXT_RD;
                        end
                    end else if (buf_q) begin
                        if (!wb_full) begin
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end
                    end else if (wb_empty) begin
                        state_q <= ST_EXT_WR;
                    end
                end
                ST_FILL: begin
                    if (mem_ack) begin
                        if (fill_cnt_q == req_off) rdata_q <= mem_rdata;
                        if (fill_cnt_q == LAST_OFF) begin
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            fill_cnt_q <= fill_cnt_q + 1'b1;
                        end
                    end
                end
                ST_EXT_RD: begin
                    if (mem_ack) begin
                        rdata_q <= mem_rdata;
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                ST_EXT_WR: begin
                    if (mem_ack) begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Requester-side outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        done      = done_q;
        rdata     = rdata_q;
    end

    logic unused_lsb;
    assign unused_lsb = ^req_addr[BYTE_W-1:0];

endmodule

// File: rtl/dcp_checker.sv
// Protocol and ordering checks for dcache_policy_ctrl, attached by bind.
// Observes ports plus the write-buffer status signals of the top.
module dcp_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic              req_ready,
    input logic              mem_req,
    input logic              mem_ack,
    input logic              mem_write,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              wb_empty,
    input logic              wb_full,
    input logic              wb_push
);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_DONE_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready); // R11

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)
                                   && $stable(mem_write) && $stable(mem_wdata))); // R12

    AST_READ_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_write) |-> wb_empty); // R10

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        wb_push |-> !wb_full); // R9

endmodule

bind dcache_policy_ctrl dcp_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .req_ready (req_ready),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_write (mem_write),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .wb_empty  (wb_empty),
    .wb_full   (wb_full),
    .wb_push   (wb_push)
);

// File: tb/sim_dcache_policy_ctrl.sv
// Self-checking bench: directed corner cases, then seeded random traffic.
module sim_dcache_policy_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        cache_en = 1'b0, xlat_en = 1'b0, pg_cache = 1'b0, pg_buf = 1'b0;
    logic        req_ready, done;
    logic [31:0] rdata;
    logic        mem_req, mem_write;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0, fails = 0;
    int rd_cnt = 0, wr_cnt = 0, acc_wr = 0, lat = 0;
    bit mem_hold = 1'b0, finished = 1'b0;
    logic [31:0] arch [int unsigned];
    logic [31:0] phys [int unsigned];
    logic [31:0] rq [$];
    bit          mv [16];
    logic [22:0] mt [16];

    always #2 clk = ~clk;

    dcache_policy_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .cache_en(cache_en), .xlat_en(xlat_en), .pg_cache(pg_cache), .pg_buf(pg_buf),
        .done(done), .rdata(rdata), .mem_req(mem_req), .mem_write(mem_write),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] init_word(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    endfunction

    function automatic logic [31:0] arch_rd(input logic [31:0] a);
        return arch.exists(a) ? arch[a] : init_word(a);
    endfunction

    function automatic logic [31:0] phys_rd(input logic [31:0] a);
        return phys.exists(a) ? phys[a] : init_word(a);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Memory model: random latency, optional hold, ordering check on reads
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0;
            lat = 0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req && !mem_hold) begin
            if (lat == 0) begin
                mem_ack = 1'b1;
                lat = $urandom % 3;
                if (mem_write) begin
                    phys[mem_addr] = mem_wdata;
                    wr_cnt++;
                end else begin
                    mem_rdata = phys_rd(mem_addr);
                    rd_cnt++;
                    rq.push_back(mem_addr);
                    chk(wr_cnt == acc_wr, "R10", "earlier stores in memory before read",
                        wr_cnt, acc_wr);
                end
            end else begin
                lat--;
            end
        end
    end

    task automatic issue(input bit w, input logic [31:0] a, input logic [31:0] d,
                         input bit ce, input bit xe, input bit c, input bit b);
        @(negedge clk);
        chk(req_ready == 1'b1, "R11", "ready while idle", req_ready, 1);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        cache_en = ce; xlat_en = xe; pg_cache = c; pg_buf = b;
        rq.delete();
        @(posedge clk);
        if (w) begin
            acc_wr++;
            arch[a] = d;
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(input int limit, output bit got, output logic [31:0] rv);
        got = 1'b0;
        rv = '0;
        for (int i = 0; i < limit; i++) begin
            if (done) begin
                got = 1'b1;
                rv = rdata;
                break;
            end
            @(negedge clk);
        end
        if (got) begin
            @(negedge clk);
            chk(done == 1'b0, "R11", "done lasts one cycle", done, 0);
        end
    endtask

    task automatic run(input bit w, input logic [31:0] a, input logic [31:0] d,
                       input bit ce, input bit xe, input bit c, input bit b,
                       input string tag);
        bit on, ec, eb, miss, got;
        int rd0, exp_n;
        logic [3:0]  idx;
        logic [22:0] tg;
        logic [31:0] exp_rd, rv, base;
        on = ce & xe;
        ec = on & c;
        eb = on & (b | c);
        idx = a[8:5];
        tg = a[31:9];
        base = {a[31:5], 5'b0};
        miss = ec && !(mv[idx] && mt[idx] == tg);
        exp_rd = arch_rd(a);
        rd0 = rd_cnt;
        issue(w, a, d, ce, xe, c, b);
        wait_done(500, got, rv);
        chk(got, tag, "request completes", 32'(got), 1);
        if (!w) begin
            chk(rv == exp_rd, tag, "read data", rv, exp_rd);
            exp_n = !ec ? 1 : (miss ? 8 : 0);
            chk(rd_cnt - rd0 == exp_n, tag, "external read count", rd_cnt - rd0, exp_n);
            if (miss) begin
                if (rq.size() == 8)
                    for (int i = 0; i < 8; i++)
                        chk(rq[i] == base + 32'(4 * i), "R5", "linefill order", rq[i],
                            base + 32'(4 * i));
                mv[idx] = 1'b1;
                mt[idx] = tg;
            end
        end else if (!eb) begin
            chk(wr_cnt == acc_wr, tag, "unbuffered store in memory at done", wr_cnt, acc_wr);
        end else begin
            chk(rd_cnt == rd0, tag, "buffered store makes no read", rd_cnt, rd0);
        end
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        bit got;
        logic [31:0] rv;
        int w0;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        chk(done == 1'b0, "R1", "done low after reset", done, 0);
        chk(mem_req == 1'b0, "R1", "no memory request after reset", mem_req, 0);

        // R5 miss then hit in the same line
        run(0, 32'h0000_1048, 0, 1, 1, 1, 0, "R5");
        run(0, 32'h0000_105C, 0, 1, 1, 1, 0, "R5");
        // R6 write-through hit, then read hit sees new data
        run(1, 32'h0000_1044, 32'hCAFE_0001, 1, 1, 1, 0, "R6");
        run(0, 32'h0000_1044, 0, 1, 1, 1, 0, "R6");
        // R8 write-back pair behaves as write-through
        run(1, 32'h0000_1050, 32'hCAFE_0002, 1, 1, 1, 1, "R8");
        run(0, 32'h0000_1050, 0, 1, 1, 1, 1, "R8");
        run(1, 32'h0000_1500, 32'hCAFE_0003, 1, 1, 1, 1, "R8");
        run(0, 32'h0000_1500, 0, 1, 1, 1, 1, "R8");
        // R7 write-through miss does not allocate
        run(1, 32'h0000_1604, 32'hCAFE_0004, 1, 1, 1, 0, "R7");
        run(0, 32'h0000_1604, 0, 1, 1, 1, 0, "R7");
        // R2 global bits off: page bits ignored, cached line not used
        run(0, 32'h0000_1048, 0, 1, 0, 1, 1, "R2");
        run(0, 32'h0000_1048, 0, 0, 1, 1, 1, "R2");
        run(0, 32'h0000_1800, 0, 1, 0, 1, 0, "R2");
        run(0, 32'h0000_1800, 0, 1, 0, 1, 0, "R2");
        run(1, 32'h0000_8010, 32'hCAFE_0005, 0, 0, 1, 1, "R2");
        // R3 uncached, unbuffered
        run(1, 32'h0000_8014, 32'hCAFE_0006, 1, 1, 0, 0, "R3");
        run(0, 32'h0000_8014, 0, 1, 1, 0, 0, "R3");
        // R4 and R9: buffered stores with memory frozen
        repeat (30) @(negedge clk);
        mem_hold = 1'b1;
        w0 = wr_cnt;
        for (int k = 0; k < 4; k++)
            run(1, 32'h0000_8100 + 32'(4 * k), 32'hBEEF_0000 + 32'(k), 1, 1, 0, 1, "R4");
        chk(wr_cnt == w0, "R4", "buffered stores done before memory write", wr_cnt, w0);
        issue(1, 32'h0000_8110, 32'hBEEF_0004, 1, 1, 0, 1);
        wait_done(40, got, rv);
        chk(!got, "R9", "fifth store held while buffer full", 32'(got), 0);
        mem_hold = 1'b0;
        wait_done(200, got, rv);
        chk(got, "R9", "fifth store completes after drain", 32'(got), 1);
        run(0, 32'h0000_8104, 0, 1, 1, 0, 1, "R4");

        // Random phase
        for (int n = 0; n < 500; n++) begin
            bit w, ce, xe, c, b;
            logic [31:0] a;
            w  = 1'($urandom % 2);
            ce = ($urandom % 4) != 0;
            xe = ($urandom % 4) != 0;
            c  = 1'($urandom % 2);
            b  = 1'($urandom % 2);
            if (c && ((ce && xe) || !w))
                a = 32'h0000_1000 + 32'(($urandom % 24) * 32) + 32'(($urandom % 8) * 4);
            else
                a = 32'h0000_8000 + 32'(($urandom % 64) * 4);
            run(w, a, $urandom, ce, xe, c, b, "R10");
        end

        // Final memory image equals last written values
        repeat (60) @(negedge clk);
        foreach (arch[k])
            chk(phys_rd(k) == arch[k], "R10", "final memory word", phys_rd(k), arch[k]);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule